// File: doc/BRIEF.md
# Bipolar DAC Word Formatter

This block turns a signed setpoint into the 16-bit word that a bipolar 12-bit digital-to-analog output channel loads. The setpoint's nominal span is -10000 to +10000, which maps to an analog swing of -10 V to +10 V.

Any input outside that span is first limited to the nearest end of the span. The limited value is then scaled to a 12-bit two's-complement code. The code is placed in the upper twelve bits of the output word, with the bottom four bits cleared.

The block is a single registered stage. A setpoint offered with `in_valid` high appears as a formatted word, with `out_valid` high, one clock later. Between updates the word holds its last value.

Top module: `dacfmt`

## Requirements
- R1: A setpoint above +10000 gives the same output as +10000, which is the word 0x7FF0 (code +2047).
- R2: A setpoint below -10000 gives the same output as -10000, which is the word 0x8010 (code -2047).
- R3: For an in-range setpoint v, the code is (v × 2047) / 10000 truncated toward zero. The code always lies within -2048..+2047. Examples: 4 gives 0, 5 gives 1, and -5 gives -1.
- R4: The 12-bit code occupies bits 15:4 of `out_word` in two's complement. Bits 3:0 are always zero.
- R5: `out_valid` in a cycle equals `in_valid` of the previous cycle, so a word appears one clock after its setpoint.
- R6: A synchronous active-high `rst` sets `out_word` to 0x0000 and `out_valid` to 0 at the next clock edge, whatever the inputs are.
- R7: When `in_valid` is low, `out_word` keeps its previous value and `in_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Setpoint strobe |
| in_data | input | 16 | Signed setpoint |
| out_valid | output | 1 | Word strobe, one cycle after `in_valid` |
| out_word | output | 16 | Left-justified 12-bit DAC code |

## Verification
The assertions check the following on every clock:
- the limiter output stays within the full-scale span;
- the scaled code stays within the 12-bit range;
- saturated inputs produce the two end words;
- the strobe lags the input strobe by one cycle;
- the word holds while no strobe is present;
- reset clears the word and the strobe.

Exact agreement with the truncating scale formula for each individual setpoint can only be shown by the bench. The bench sweeps every 16-bit input value and compares each result against an independently computed word.

// File: rtl/dacfmt_pkg.sv
package dacfmt_pkg;
    localparam int IN_W    = 16;
    localparam int CODE_W  = 12;
    localparam int OUT_W   = 16;
    localparam int PAD_W   = OUT_W - CODE_W;
    localparam int FULL_SCALE_DEF = 10000;
    localparam int CODE_MAX_DEF   = (1 << (CODE_W - 1)) - 1;

    typedef logic signed [IN_W-1:0]   setpoint_t;
    typedef logic signed [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t            code;
        logic [PAD_W-1:0] pad;
    } dac_word_t;

    typedef struct packed {
        logic      vld;
        dac_word_t word;
    } stage_t;

    function automatic dac_word_t pack_code(code_t c);
        dac_word_t w;
        w.code = c;
        w.pad  = '0;
        return w;
    endfunction
endpackage

// File: rtl/dacfmt_clamp.sv
module dacfmt_clamp
    import dacfmt_pkg::*;
#(
    parameter int FULL_SCALE = FULL_SCALE_DEF
) (
    input  setpoint_t raw,
    output setpoint_t lim
);
    localparam setpoint_t HI = setpoint_t'(FULL_SCALE);
    localparam setpoint_t LO = -HI;

    always_comb begin
        if (raw > HI)      lim = HI;
        else if (raw < LO) lim = LO;
        else               lim = raw;
    end

    // R1 and R2: the limited value never leaves the full-scale span
    always_comb begin
        if (!$isunknown(raw)) begin
            assert_lim_span_R1: assert (lim <= HI && lim >= LO);
        end
    end
endmodule

// File: rtl/dacfmt_scale.sv
module dacfmt_scale
    import dacfmt_pkg::*;
#(
    parameter int FULL_SCALE = FULL_SCALE_DEF,
    parameter int CODE_MAX   = CODE_MAX_DEF
) (
    input  setpoint_t lim,
    output code_t     code
);
    localparam int PROD_W = IN_W + CODE_W;
    localparam logic signed [PROD_W-1:0] K_MUL = PROD_W'(CODE_MAX);
    localparam logic signed [PROD_W-1:0] K_DIV = PROD_W'(FULL_SCALE);

    logic signed [PROD_W-1:0] ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] quot;

    always_comb begin
        ext  = {{CODE_W{lim[IN_W-1]}}, lim};
        prod = ext * K_MUL;
        quot = prod / K_DIV;
        code = quot[CODE_W-1:0];
    end

    // R3: the scaled code stays inside the symmetric 12-bit range
    always_comb begin
        if (!$isunknown(lim) && lim <= setpoint_t'(FULL_SCALE) && lim >= -setpoint_t'(FULL_SCALE)) begin
            assert_code_range_R3: assert (quot <= K_MUL && quot >= -K_MUL);
        end
    end
endmodule

// File: rtl/dacfmt.sv
module dacfmt
    import dacfmt_pkg::*;
#(
    parameter int FULL_SCALE = FULL_SCALE_DEF,
    parameter int CODE_MAX   = CODE_MAX_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_word
);
    localparam logic [OUT_W-1:0] WORD_TOP = {CODE_W'(CODE_MAX), PAD_W'(0)};
    localparam logic [OUT_W-1:0] WORD_BOT = {CODE_W'(-CODE_MAX), PAD_W'(0)};

    setpoint_t lim;
    code_t     code;
    stage_t    st_q;

    dacfmt_clamp #(.FULL_SCALE(FULL_SCALE)) u_clamp (
        .raw (setpoint_t'(in_data)),
        .lim (lim)
    );

    dacfmt_scale #(.FULL_SCALE(FULL_SCALE), .CODE_MAX(CODE_MAX)) u_scale (
        .lim  (lim),
        .code (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.vld <= in_valid;
            if (in_valid) st_q.word <= pack_code(code);
        end
    end

    assign out_valid = st_q.vld;
    assign out_word  = st_q.word;

    assert_high_sat_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past($signed(in_data)) > FULL_SCALE) |-> out_word == WORD_TOP);

    assert_low_sat_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past($signed(in_data)) < -FULL_SCALE) |-> out_word == WORD_BOT);

    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_word[PAD_W-1:0] == '0);

    assert_strobe_lag_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    assert_reset_clear_R6: assert property (@(posedge clk)
        $past(rst) |-> (out_word == '0 && !out_valid));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> $stable(out_word));
endmodule

// File: tb/dacfmt_test.sv
module dacfmt_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_word;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    dacfmt uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_word(int v);
        int c;
        c = (v > 10000) ? 10000 : ((v < -10000) ? -10000 : v);
        c = (c * 2047) / 10000;
        return {c[11:0], 4'b0000};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int v, bit vld);
        @(negedge clk);
        in_data  = v[15:0];
        in_valid = vld;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        logic [15:0] exp_w;
        string tag;

        repeat (3) @(posedge clk);
        #1;
        // R6: reset state
        check(out_word == 16'h0000, "R6", out_word, 0);
        check(out_valid == 1'b0, "R6", out_valid, 0);
        @(negedge clk);
        rst = 1'b0;

        // full sweep of every input value; R1, R2, R3, R4, R5
        for (int v = -32768; v <= 32767; v++) begin
            step(v, 1'b1);
            exp_w = model_word(v);
            tag = (v > 10000) ? "R1" : ((v < -10000) ? "R2" : "R3");
            check(out_word == exp_w, tag, out_word, exp_w);
            check(out_word[3:0] == 4'h0, "R4", out_word[3:0], 0);
            check(out_valid == 1'b1, "R5", out_valid, 1);
        end

        // end words and small-value truncation spot checks
        step(32767, 1'b1);
        check(out_word == 16'h7FF0, "R1", out_word, 16'h7FF0);
        step(-32768, 1'b1);
        check(out_word == 16'h8010, "R2", out_word, 16'h8010);
        step(4, 1'b1);
        check(out_word == 16'h0000, "R3", out_word, 0);
        step(5, 1'b1);
        check(out_word == 16'h0010, "R3", out_word, 16'h0010);
        step(-5, 1'b1);
        check(out_word == 16'hFFF0, "R3", out_word, 16'hFFF0);

        // R7: idle cycles leave the word untouched
        step(1234, 1'b1);
        held = out_word;
        check(held == model_word(1234), "R7", held, model_word(1234));
        step(-5000, 1'b0);
        check(out_word == held, "R7", out_word, held);
        check(out_valid == 1'b0, "R5", out_valid, 0);
        step(20000, 1'b0);
        check(out_word == held, "R7", out_word, held);
        step(-20000, 1'b1);
        check(out_valid == 1'b1, "R5", out_valid, 1);
        check(out_word == 16'h8010, "R2", out_word, 16'h8010);

        // R6: reset during active input
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_data = 16'd20000;
        @(posedge clk);
        #1;
        check(out_word == 16'h0000, "R6", out_word, 0);
        check(out_valid == 1'b0, "R6", out_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        step(0, 1'b0);
        check(out_word == 16'h0000, "R7", out_word, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule